// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block derives the bit clock of a synchronous serial master from a faster core clock. The divide happens in two cascaded stages. A prescaler accepts an 8-bit divisor whose least significant bit is discarded, so it only ever divides by an even amount. A rate divider then divides that result again by one plus an 8-bit rate value. One full bit-clock period therefore spans `P = Dp * (1 + rate)` core cycles. `Dp` is the prescale value with bit 0 forced to zero, and a result of zero is replaced by 2. Because `Dp` is even, each half period is exactly `P/2` core cycles.

The bit clock toggles only while the block is enabled and a transfer is marked active. Otherwise it rests at an idle level chosen by a polarity input. When a transfer ends in the middle of a half period spent away from the idle level, that half period runs to its full length before the clock parks, so no shortened pulse appears. Each transfer restarts both counters from zero. Downstream shift logic does not need to sample the generated clock. It receives two registered one-cycle strobes instead: one marks each move away from the idle level, the other each return to it. A parked flag reports when the clock is held.

Top module: `sclk_gen`

## Requirements
- R1: The bit-clock period is `Dp * (1 + rate_i)` core cycles. `Dp` is `prescale_i` with bit 0 cleared, or 2 when that value is zero.
- R2: While the clock runs, every high phase and every low phase lasts exactly `Dp/2 * (1 + rate_i)` core cycles.
- R3: Bit 0 of `prescale_i` has no effect: an odd value divides exactly like the even value one below it.
- R4: A `prescale_i` of 0 or 1 divides like a value of 2, so the clock still runs.
- R5: While parked (`clk_idle_o` = 1), `sclk_o` equals the polarity level: 0 when `polarity_i` = 0, 1 when it is 1.
- R6: The clock runs only when `enable_i` and `active_i` are both 1. With `enable_i` = 0 the block stays parked, whatever `active_i` does.
- R7: The first move away from the idle level appears on `sclk_o` one half period (R2) after the first core-clock edge that sees the run request. The counters restart from zero for every transfer.
- R8: When the run request drops during a half period away from the idle level, that half period completes at full length, `sclk_o` then returns to the idle level and the block parks. When the request drops during a half period at the idle level, the block parks at the next edge with no further clock edge.
- R9: `lead_tick_o` is high for exactly the core cycle in which `sclk_o` first shows a move away from the idle level. `trail_tick_o` is high for exactly the core cycle in which it first shows a return. The two strobes are never high together, and neither pulses without a change on `sclk_o`.
- R10: The polarity is captured only while parked. A change on `polarity_i` during a transfer does not disturb the running clock and takes effect after the block parks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_i | input | 8 | Prescale divisor; bit 0 ignored |
| rate_i | input | 8 | Rate value; second stage divides by 1 + rate_i |
| enable_i | input | 1 | Block enable |
| active_i | input | 1 | Transfer-active qualifier |
| polarity_i | input | 1 | Idle level of the bit clock |
| sclk_o | output | 1 | Generated bit clock |
| lead_tick_o | output | 1 | One-cycle strobe on a move away from the idle level |
| trail_tick_o | output | 1 | One-cycle strobe on a return to the idle level |
| clk_idle_o | output | 1 | High while the clock is parked |

## Verification
The following hold on every cycle and are checked by assertions:
- the two strobes are mutually exclusive and coincide with changes on `sclk_o`;
- the clock holds the captured polarity level while parked;
- a disabled block never leaves the parked state;
- a lead strobe never occurs while parked.

The following depend on counting cycles against the programmed divisors and on the order of stimulus, so only the directed scenarios show them:
- the exact period and half-period lengths for several prescale and rate settings, including odd, zero and extreme values;
- the delay to the first edge;
- the full-length final half period after a stop;
- deferred polarity capture.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    // Operating state of the bit-clock phase controller.
    typedef enum logic [1:0] {
        CK_PARK  = 2'd0,  // clock held at idle level, counters cleared
        CK_RUN   = 2'd1,  // clock toggling for an active transfer
        CK_DRAIN = 2'd2   // request gone, finishing the non-idle half period
    } ck_state_e;

    // Registered controller state.
    typedef struct packed {
        ck_state_e state;
        logic      phase;  // 0: at idle level, 1: away from idle level
        logic      pol;    // captured idle level
        logic      lead;   // strobe: moved away from idle level
        logic      trail;  // strobe: returned to idle level
    } ck_ctrl_t;

endpackage

// File: rtl/sclk_prescale.sv
// First stage: even-only prescaler, producing one step every Dp/2 cycles.
module sclk_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en_i,
    input  logic             clear_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             step_o
);
    localparam int HALF_W = PRE_W - 1;

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } pre_state_t;

    pre_state_t        s_d, s_q;
    logic [HALF_W-1:0] half_div;
    logic [HALF_W-1:0] last_cnt;

    // Dropping bit 0 halves the even divisor; zero maps to a divisor of 2.
    always_comb begin
        half_div = prescale_i[PRE_W-1:1];
        if (half_div == '0) begin
            half_div = HALF_W'(1);
        end
        last_cnt = half_div - HALF_W'(1);
    end

    assign step_o = count_en_i && (s_q.cnt == last_cnt);

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (count_en_i) begin
            s_d.cnt = step_o ? '0 : s_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sclk_rate_div.sv
// Second stage: counts 1 + rate prescaler steps per half period.
module sclk_rate_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              clear_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              toggle_o
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } rate_state_t;

    rate_state_t s_d, s_q;

    assign toggle_o = step_i && (s_q.cnt == rate_i);

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (step_i) begin
            s_d.cnt = toggle_o ? '0 : s_q.cnt + RATE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sclk_phase_ctrl.sv
// Run/park control, clock phase, polarity capture and edge strobes.
module sclk_phase_ctrl
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req_i,
    input  logic toggle_i,
    input  logic polarity_i,
    output logic count_en_o,
    output logic clear_o,
    output logic sclk_o,
    output logic lead_o,
    output logic trail_o,
    output logic idle_o
);
    ck_ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.lead  = 1'b0;
        c_d.trail = 1'b0;
        unique case (c_q.state)
            CK_PARK: begin
                c_d.pol   = polarity_i;
                c_d.phase = 1'b0;
                if (run_req_i) begin
                    c_d.state = CK_RUN;
                end
            end
            CK_RUN: begin
                if (!run_req_i && !c_q.phase) begin
                    // already at idle level: stop without another edge
                    c_d.state = CK_PARK;
                end else if (toggle_i) begin
                    c_d.phase = ~c_q.phase;
                    c_d.lead  = ~c_q.phase;
                    c_d.trail = c_q.phase;
                    if (!run_req_i) begin
                        c_d.state = CK_PARK;
                    end
                end else if (!run_req_i) begin
                    c_d.state = CK_DRAIN;
                end
            end
            CK_DRAIN: begin
                if (toggle_i) begin
                    c_d.phase = 1'b0;
                    c_d.trail = 1'b1;
                    c_d.state = CK_PARK;
                end
            end
            default: begin
                c_d.state = CK_PARK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_en_o = (c_q.state != CK_PARK);
    assign clear_o    = (c_q.state == CK_PARK);
    assign sclk_o     = c_q.phase ^ c_q.pol;
    assign lead_o     = c_q.lead;
    assign trail_o    = c_q.trail;
    assign idle_o     = (c_q.state == CK_PARK);
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              enable_i,
    input  logic              active_i,
    input  logic              polarity_i,
    output logic              sclk_o,
    output logic              lead_tick_o,
    output logic              trail_tick_o,
    output logic              clk_idle_o
);
    logic run_req;
    logic count_en;
    logic clear;
    logic pre_step;
    logic half_done;

    assign run_req = enable_i && active_i;

    sclk_prescale #(.PRE_W(PRE_W)) i_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en),
        .clear_i    (clear),
        .prescale_i (prescale_i),
        .step_o     (pre_step)
    );

    sclk_rate_div #(.RATE_W(RATE_W)) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (pre_step),
        .clear_i  (clear),
        .rate_i   (rate_i),
        .toggle_o (half_done)
    );

    sclk_phase_ctrl i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_req_i  (run_req),
        .toggle_i   (half_done),
        .polarity_i (polarity_i),
        .count_en_o (count_en),
        .clear_o    (clear),
        .sclk_o     (sclk_o),
        .lead_o     (lead_tick_o),
        .trail_o    (trail_tick_o),
        .idle_o     (clk_idle_o)
    );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic polarity_i,
    input logic sclk_o,
    input logic lead_tick_o,
    input logic trail_tick_o,
    input logic clk_idle_o
);
    AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_idle_o && $past(clk_idle_o) && $past(rst_n)) |-> (sclk_o == $past(polarity_i))); // R5
    AST_EDGE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clk_idle_o) && $past(rst_n) && (sclk_o != $past(sclk_o))) |-> (lead_tick_o || trail_tick_o)); // R9
    AST_TICK_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lead_tick_o || trail_tick_o) && $past(rst_n)) |-> (sclk_o != $past(sclk_o))); // R9
    AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_tick_o && trail_tick_o)); // R9
    AST_NO_LEAD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        lead_tick_o |-> !clk_idle_o); // R8
    AST_DISABLED_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_idle_o) && !$past(enable_i) && $past(rst_n)) |-> clk_idle_o); // R6
endmodule

bind sclk_gen sclk_gen_chk i_sclk_gen_chk (.*);

// File: tb/test_sclk_gen.sv
module test_sclk_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prescale_i = 8'd2;
    logic [7:0] rate_i = 8'd0;
    logic       enable_i = 1'b0;
    logic       active_i = 1'b0;
    logic       polarity_i = 1'b0;
    logic       sclk_o, lead_tick_o, trail_tick_o, clk_idle_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_gen i_sclk_gen (
        .clk(clk), .rst_n(rst_n), .prescale_i(prescale_i), .rate_i(rate_i),
        .enable_i(enable_i), .active_i(active_i), .polarity_i(polarity_i),
        .sclk_o(sclk_o), .lead_tick_o(lead_tick_o), .trail_tick_o(trail_tick_o),
        .clk_idle_o(clk_idle_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int half_len(input int pre, input int rate);
        int h = (pre & 8'hFE) >> 1;
        if (h == 0) h = 1;
        return h * (rate + 1);
    endfunction

    // One sample at the falling edge; checks strobes against the clock change (R9).
    task automatic watch(input bit pol, inout logic prev, output bit changed);
        @(negedge clk);
        changed = (sclk_o != prev);
        if (changed || lead_tick_o || trail_tick_o) begin
            check(lead_tick_o == (changed && (sclk_o != pol)), "R9 lead", int'(lead_tick_o),
                  int'(changed && (sclk_o != pol)));
            check(trail_tick_o == (changed && (sclk_o == pol)), "R9 trail", int'(trail_tick_o),
                  int'(changed && (sclk_o == pol)));
        end
        prev = sclk_o;
    endtask

    task automatic test_reset();
        check(sclk_o == 1'b0, "R5 reset level", int'(sclk_o), 0);
        check(clk_idle_o == 1'b1, "R5 reset parked", int'(clk_idle_o), 1);
        check(!lead_tick_o && !trail_tick_o, "R9 reset strobes", int'(lead_tick_o | trail_tick_o), 0);
    endtask

    // Full transfer: first edge, five edges of spacing, stop while away from idle (R1 R2 R3 R4 R7 R8).
    task automatic run_case(input int pre, input int rate, input bit pol, input string tag);
        int   h = half_len(pre, rate);
        int   idx = 0;
        int   last = 0;
        int   nchg = 0;
        int   wait_n = 0;
        bit   chg;
        logic prev;
        prescale_i = 8'(pre);
        rate_i = 8'(rate);
        polarity_i = pol;
        enable_i = 1'b1;
        active_i = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk_o == pol, {"R5 parked level ", tag}, int'(sclk_o), int'(pol));
        check(clk_idle_o == 1'b1, {"R5 parked flag ", tag}, int'(clk_idle_o), 1);
        active_i = 1'b1;
        prev = sclk_o;
        while (nchg < 5 && idx < 6 * h + 10) begin
            watch(pol, prev, chg);
            idx++;
            if (chg) begin
                if (nchg == 0) check(idx == h + 1, {"R7 first edge ", tag}, idx, h + 1);
                else check(idx - last == h, {"R1 R2 half period ", tag}, idx - last, h);
                last = idx;
                nchg++;
            end
        end
        check(nchg == 5, {"R1 edge count ", tag}, nchg, 5);
        active_i = 1'b0;
        chg = 1'b0;
        while (!chg && wait_n < 2 * h + 4) begin
            watch(pol, prev, chg);
            wait_n++;
        end
        check(wait_n == h, {"R8 final half full length ", tag}, wait_n, h);
        check(sclk_o == pol, {"R8 returns to idle ", tag}, int'(sclk_o), int'(pol));
        for (int i = 0; i < 2 * h + 4; i++) begin
            watch(pol, prev, chg);
            if (chg) check(1'b0, {"R8 no edge after stop ", tag}, 1, 0);
        end
        check(clk_idle_o == 1'b1, {"R5 parked after stop ", tag}, int'(clk_idle_o), 1);
    endtask

    task automatic test_enable_gate();
        int   h = half_len(4, 1);
        int   idx = 0;
        int   nchg = 0;
        bit   chg;
        logic prev;
        prescale_i = 8'd4;
        rate_i = 8'd1;
        polarity_i = 1'b0;
        enable_i = 1'b0;
        active_i = 1'b1;
        @(negedge clk);
        prev = sclk_o;
        for (int i = 0; i < 40; i++) begin
            watch(1'b0, prev, chg);
            if (chg) nchg++;
        end
        check(nchg == 0, "R6 no clock while disabled", nchg, 0);
        check(clk_idle_o == 1'b1, "R6 parked while disabled", int'(clk_idle_o), 1);
        enable_i = 1'b1;
        chg = 1'b0;
        while (!chg && idx < 4 * h) begin
            watch(1'b0, prev, chg);
            idx++;
        end
        check(idx == h + 1, "R6 R7 first edge after enable", idx, h + 1);
        enable_i = 1'b0;
        repeat (2 * h + 4) @(negedge clk);
        check(clk_idle_o == 1'b1 && sclk_o == 1'b0, "R6 parked after disable", int'(clk_idle_o), 1);
        active_i = 1'b0;
    endtask

    task automatic test_short_request();
        int   nchg = 0;
        bit   chg;
        logic prev;
        prescale_i = 8'd2;
        rate_i = 8'd3;
        polarity_i = 1'b0;
        enable_i = 1'b1;
        @(negedge clk);
        prev = sclk_o;
        active_i = 1'b1;
        @(negedge clk);
        active_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            watch(1'b0, prev, chg);
            if (chg) nchg++;
        end
        check(nchg == 0, "R8 stop during idle half gives no edge", nchg, 0);
        check(clk_idle_o == 1'b1, "R8 parked after short request", int'(clk_idle_o), 1);
    endtask

    task automatic test_polarity_hold();
        int   h = half_len(2, 3);
        int   idx = 0;
        bit   chg;
        logic prev;
        prescale_i = 8'd2;
        rate_i = 8'd3;
        polarity_i = 1'b0;
        enable_i = 1'b1;
        repeat (2) @(negedge clk);
        prev = sclk_o;
        active_i = 1'b1;
        chg = 1'b0;
        while (!chg && idx < 4 * h) begin
            watch(1'b0, prev, chg);
            idx++;
        end
        check(sclk_o == 1'b1, "R10 first move away", int'(sclk_o), 1);
        polarity_i = 1'b1;
        idx = 0;
        chg = 1'b0;
        while (!chg && idx < 4 * h) begin
            watch(1'b0, prev, chg);
            idx++;
        end
        check(idx == h, "R10 half period kept after polarity change", idx, h);
        check(sclk_o == 1'b0, "R10 old idle level kept during run", int'(sclk_o), 0);
        active_i = 1'b0;
        repeat (4) @(negedge clk);
        check(clk_idle_o == 1'b1, "R10 parked", int'(clk_idle_o), 1);
        check(sclk_o == 1'b1, "R10 new level after park", int'(sclk_o), 1);
        polarity_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_case(2, 0, 1'b0, "pre2 rate0");
        run_case(3, 2, 1'b0, "R3 odd pre3 rate2");
        run_case(0, 1, 1'b1, "R4 pre0 rate1 pol1");
        run_case(1, 0, 1'b0, "R4 pre1 rate0");
        run_case(10, 4, 1'b1, "pre10 rate4 pol1");
        run_case(255, 0, 1'b0, "R3 pre255 rate0");
        run_case(2, 255, 1'b0, "pre2 rate255");
        test_enable_gate();
        test_short_request();
        run_case(2, 3, 1'b0, "R7 restart after short request");
        test_polarity_hold();
        run_case(6, 2, 1'b1, "pre6 rate2 pol1");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule